// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address order for a single memory burst. A start pulse captures a starting column address, a burst length of 4 or 8 beats, and an ordering mode, which is either sequential or interleaved. After that the block puts out one column address per clock cycle, marked by a valid flag. A done flag pulses once the final beat has gone out.

Only the low column bits inside the burst field are reordered. That field is two bits wide for 4-beat bursts and three bits wide for 8-beat bursts. Every bit above the field passes through unchanged.

A burst always runs to completion, because there is no way to stop it early. Any start pulse seen while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after it is released, valid_o, busy_o and done_o are low until a start is accepted.
- R2: A start_i sampled while idle is accepted. The first address appears on the next cycle, and valid_o and busy_o then stay high for exactly 4 consecutive cycles (len8_i=0) or 8 consecutive cycles (len8_i=1), with one new address each cycle.
- R3: 4-beat sequential (len8_i=0, ilv_i=0): at beat k, bits [1:0] equal (start[1:0]+k) mod 4, and bit 2 and above equal the start address. Start 1 gives 1,2,3,0.
- R4: 8-beat sequential (len8_i=1, ilv_i=0): bits [1:0] equal (start[1:0]+k) mod 4. Bit 2 equals start[2] for beats 0-3 and is inverted for beats 4-7. Start 6 gives 6,7,4,5,2,3,0,1.
- R5: Interleaved (ilv_i=1): at beat k the burst field equals the start field XOR k, using 2 bits for 4-beat and 3 bits for 8-beat. Start 5 at length 8 gives 5,4,7,6,1,0,3,2.
- R6: Column bits at index 3 and above are identical to col_i on every beat.
- R7: done_o is high for exactly one cycle, the cycle right after the last beat, and valid_o is low in that cycle.
- R8: A start_i that arrives while busy_o is high is ignored, including on the last beat. The running burst and its addresses are unchanged.
- R9: col_i, len8_i and ilv_i are captured at acceptance. Changing them during a burst has no effect on that burst.
- R10: A start_i sampled in the done cycle is accepted, so the next burst's first beat follows one cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat address |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
Two events can fall in the same cycle, and both are provoked on purpose. The first is the end of one burst, marked by the done pulse, together with the acceptance of a new start. The second is the last beat of a burst together with a start request that must be refused. The bench raises start_i exactly in the done cycle and exactly on the final beat. It then compares every following cycle against a behavioural queue model: an accepted start must produce a first beat one cycle after done_o, and a refused start must leave the running addresses and the burst length untouched.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 3;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              len8_i,
  output logic              accept_o,
  output logic              active_o,
  output logic              len8_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              done_o
);
  localparam logic [BEAT_W-1:0] LAST4 = BEAT_W'(3);
  localparam logic [BEAT_W-1:0] LAST8 = BEAT_W'(7);

  logic active_q, len8_q, done_q;
  logic [BEAT_W-1:0] beat_q;
  logic last;

  assign accept_o = go_i && !active_q;
  assign last     = active_q && (beat_q == (len8_q ? LAST8 : LAST4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      len8_q   <= 1'b0;
      done_q   <= 1'b0;
      beat_q   <= '0;
    end else begin
      done_q <= last;
      if (accept_o) begin
        active_q <= 1'b1;
        len8_q   <= len8_i;
        beat_q   <= '0;
      end else if (last) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else if (active_q) begin
        beat_q   <= beat_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign len8_o   = len8_q;
  assign beat_o   = beat_q;
  assign done_o   = done_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              len8_i,
  input  order_e            order_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] fld, eff_beat;

  // 4-beat bursts never touch bit 2
  assign eff_beat = len8_i ? beat_i : {1'b0, beat_i[1:0]};

  always_comb begin
    if (order_i == ORD_ILV) begin
      fld = base_i[BEAT_W-1:0] ^ eff_beat;
    end else begin
      fld[1:0] = base_i[1:0] + eff_beat[1:0];
      fld[2]   = base_i[2] ^ eff_beat[2];
    end
  end

  assign col_o = {base_i[COL_W-1:BEAT_W], fld};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             len8_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             done_o
);
  logic              accept, active, len8_q;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  base_q;
  order_e            order_q;

  burst_beat_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (start_i),
    .len8_i   (len8_i),
    .accept_o (accept),
    .active_o (active),
    .len8_o   (len8_q),
    .beat_o   (beat),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_SEQ;
    end else if (accept) begin
      base_q  <= col_i;
      order_q <= ilv_i ? ORD_ILV : ORD_SEQ;
    end
  end

  burst_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i  (base_q),
    .beat_i  (beat),
    .len8_i  (len8_q),
    .order_i (order_q),
    .col_o   (col_o)
  );

  assign valid_o = active;
  assign busy_o  = active;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             busy_o,
  input logic             done_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (valid_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_START_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> valid_o); // R2
  AST_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> (run_q == 4'd4 || run_q == 4'd8)); // R2
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o && $past(valid_o))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && run_q < 4'd4) |-> busy_o); // R8
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] col_in = '0;
  logic len8 = 1'b0, ilv = 1'b0;
  logic [COL_W-1:0] col_out;
  logic valid, busy, done;

  int errors = 0, checks = 0, cycles = 0;
  int exp_q[$];
  bit exp_done = 0;
  string col_tag = "R3";
  string scen_tag = "R2";

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_i(col_in),
    .len8_i(len8), .ilv_i(ilv), .col_o(col_out), .valid_o(valid),
    .busy_o(busy), .done_o(done)
  );

  function automatic int ref_addr(int s, int k, bit l8, bit il);
    int up;
    up = s - (s % 8);
    if (il) return s ^ k;
    if (!l8) return (s - (s % 4)) + ((s % 4 + k) % 4);
    return up + ((((s % 8) / 4 + k / 4) % 2) * 4) + ((s % 4 + k) % 4);
  endfunction

  // behavioural reference, advances on each clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      exp_done = 0;
    end else if (exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      exp_done = (exp_q.size() == 0);
    end else begin
      exp_done = 0;
      if (start) begin
        for (int k = 0; k < (len8 ? 8 : 4); k++)
          exp_q.push_back(ref_addr(int'(col_in), k, len8, ilv));
        col_tag = ilv ? "R5 R6" : (len8 ? "R4 R6" : "R3 R6");
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({scen_tag, " valid"}, int'(valid), int'(exp_q.size() != 0));
      chk({scen_tag, " busy"}, int'(busy), int'(exp_q.size() != 0));
      chk("R7 done", int'(done), int'(exp_done));
      if (exp_q.size() != 0) chk({col_tag, " ", scen_tag, " col"}, int'(col_out), exp_q[0]);
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic kick(int c, bit l8, bit il);
    @(negedge clk);
    start = 1'b1; col_in = COL_W'(c); len8 = l8; ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || exp_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", int'(valid), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    // fixed examples
    kick(1, 0, 0); drain();
    kick(1, 1, 0); drain();
    kick(6, 1, 0); drain();
    kick(5, 1, 1); drain();
    kick(3, 0, 1); drain();
    // every start across every mode with upper bits set (R6)
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 4; m++) begin
        kick('h2A8 | s, m[1], m[0]); drain();
      end

    // R8: start mid-burst and on the last beat
    scen_tag = "R2 R8";
    kick('h105, 1, 0);
    @(negedge clk); start = 1'b1; col_in = 'h3F2; len8 = 0; ilv = 1;
    @(negedge clk); start = 1'b0;
    while (exp_q.size() != 1) @(negedge clk);
    start = 1'b1; col_in = 'h0F0;
    @(negedge clk); start = 1'b0;
    drain();

    // R9: inputs change during a burst
    scen_tag = "R2 R9";
    kick('h0C2, 0, 0);
    col_in = 'h3FF; len8 = 1; ilv = 1;
    drain();

    // R10: start in the done cycle
    scen_tag = "R2 R10";
    kick('h044, 1, 1);
    while (!exp_done) @(negedge clk);
    start = 1'b1; col_in = 'h1D3; len8 = 0; ilv = 0;
    @(negedge clk); start = 1'b0;
    chk("R10 first beat after done", int'(valid), 1);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule